// File: doc/BRIEF.md
# External Interrupt Pending Controller

This block keeps one processor's pending external-interrupt bits and its interrupt enable mask, and it decides when an interrupt is taken. Any master on the system bus can post an interrupt by writing an interrupt number to a single mapped 32-bit word. The number is inverted before use, so number 0 selects the most significant pending bit. A local timer alarm posts the same interrupt as a bus write of 0. The processor reads the pending bits and clears them with a write-ones-to-clear operation. It loads the enable mask directly.

The pending register is `DW` bits wide. At run time it is used as a 32-bit register (narrow mode) or as a 64-bit register (wide mode). Wide mode is in force only when the core is built wide-capable and the default-wide configuration input is high. A latched non-maskable request wins over external interrupts whenever the core signals that it can accept an interruption.

Top module: `xirq_ctrl`

## Requirements
- R1: After a synchronous reset, `cpu_pend`, `cpu_mask`, `hard_req`, `take_ext`, `take_nmi` and `bus_rd_valid` are all zero.
- R2: In narrow mode, a bus write with `bus_wr_len`==4 and data d sets pending bit (~d & 31) at the next clock edge. For example, d=0 sets bit 31, d=33 sets bit 30 and d=5 sets bit 26.
- R3: When `WIDE_OK`=1 and `cfg_wide`=1, the bit index is (~d & 63). For example, d=0 sets bit 63 and d=1 sets bit 62.
- R4: A bus write whose `bus_wr_len` is not 4 leaves `cpu_pend` unchanged. A bus read whose length is not 4 produces no `bus_rd_valid`.
- R5: A processor clear with mask v clears every pending bit that is 1 in v and leaves all other bits unchanged.
- R6: When a clear and a post fall in the same cycle, the clear is applied first and the post second, so the posted bit ends up set.
- R7: A `timer_alarm` pulse sets the bit that a bus write of 0 would set (bit 31 when narrow, bit 63 when wide). It can do so in the same cycle as a bus post, and both bits are then set.
- R8: A bus read with length 4 gives `bus_rd_valid`=1 one cycle later, with `bus_rd_data` equal to the pending register as it stood at the read edge.
- R9: `hard_req` is 1 exactly when `cpu_pend` is nonzero, in every cycle.
- R10: `take_ext` pulses for one cycle after a cycle in which all of the following hold: `take_en`=1, `psw_i`=1, no non-maskable request is pending, and (pending & mask) is nonzero.
- R11: A pulse on `nmi_req` is latched. On the next `take_en` the block pulses `take_nmi` instead of `take_ext` and drops the latched request.
- R12: `cpu_mask_we` loads `cpu_mask_data` into the mask register, which appears on `cpu_mask` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wide | input | 1 | Default-wide configuration bit |
| bus_wr_en | input | 1 | Bus write strobe to the mapped word |
| bus_wr_len | input | 3 | Access length in bytes |
| bus_wr_data | input | AW | Posted interrupt number |
| bus_rd_en | input | 1 | Bus read strobe |
| bus_rd_len | input | 3 | Read length in bytes |
| bus_rd_valid | output | 1 | Read data valid |
| bus_rd_data | output | DW | Pending register snapshot |
| timer_alarm | input | 1 | Timer alarm pulse |
| cpu_clr_en | input | 1 | Processor write-ones-to-clear strobe |
| cpu_clr_mask | input | DW | Bits to clear |
| cpu_mask_we | input | 1 | Mask register write strobe |
| cpu_mask_data | input | DW | New mask value |
| cpu_pend | output | DW | Pending bits |
| cpu_mask | output | DW | Enable mask |
| psw_i | input | 1 | Processor interrupt-enable bit |
| nmi_req | input | 1 | Non-maskable request pulse |
| take_en | input | 1 | Core can accept an interruption this cycle |
| hard_req | output | 1 | Any interrupt pending |
| take_ext | output | 1 | External interrupt taken |
| take_nmi | output | 1 | Non-maskable transfer taken |

## Verification
Posts are made with numbers whose inverted low bits land on distinct positions, and the same numbers are posted once in narrow mode and once in wide mode. This shows whether the width mask is applied. Wrong-length accesses and clears that overlap posts in the same cycle show whether the length check and the clear-then-set order are correct. The take logic is tried with the mask empty, with the mask matching, with `psw_i` low and with a latched non-maskable request. Together these show whether each gating term and the priority between the two takes are correct.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  typedef enum logic {MODE_NARROW = 1'b0, MODE_WIDE = 1'b1} width_mode_e;

  typedef enum logic [1:0] {TAKE_NONE = 2'd0, TAKE_EXT = 2'd1, TAKE_NMI = 2'd2} take_kind_e;
endpackage

// File: rtl/xirq_post_dec.sv
module xirq_post_dec
  import xirq_pkg::*;
#(
  parameter int DW      = 64,
  parameter int NW      = 32,
  parameter int AW      = 32,
  parameter int ACC_LEN = 4,
  parameter bit WIDE_OK = 1'b1
) (
  input  logic          cfg_wide,
  input  logic          bus_wr_en,
  input  logic [2:0]    bus_wr_len,
  input  logic [AW-1:0] bus_wr_data,
  input  logic          timer_alarm,
  output logic [DW-1:0] set_vec
);
  localparam int IW = $clog2(DW);
  localparam logic [IW-1:0] WIDE_LIM   = IW'(DW - 1);
  localparam logic [IW-1:0] NARROW_LIM = IW'(NW - 1);

  width_mode_e   mode;
  logic [IW-1:0] lim;
  logic [IW-1:0] bus_idx;
  logic          bus_ok;

  always_comb begin
    mode    = (WIDE_OK && cfg_wide) ? MODE_WIDE : MODE_NARROW;
    lim     = (mode == MODE_WIDE) ? WIDE_LIM : NARROW_LIM;
    bus_ok  = bus_wr_en && (bus_wr_len == 3'(ACC_LEN));
    bus_idx = ~bus_wr_data[IW-1:0] & lim;
  end

  for (genvar i = 0; i < DW; i++) begin : g_bit
    always_comb begin
      set_vec[i] = (bus_ok && (bus_idx == IW'(i))) ||
                   (timer_alarm && (lim == IW'(i)));
    end
  end
endmodule

// File: rtl/xirq_pend_reg.sv
module xirq_pend_reg #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_vec,
  input  logic          clr_en,
  input  logic [DW-1:0] clr_mask,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_data,
  output logic [DW-1:0] pend_q,
  output logic [DW-1:0] mask_q,
  output logic          req_q
);
  logic [DW-1:0] after_clr;
  logic [DW-1:0] pend_d;

  always_comb begin
    after_clr = clr_en ? (pend_q & ~clr_mask) : pend_q;
    pend_d    = after_clr | set_vec;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      mask_q <= '0;
      req_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      req_q  <= |pend_d;
      if (mask_we) mask_q <= mask_data;
    end
  end
endmodule

// File: rtl/xirq_take_arb.sv
module xirq_take_arb
  import xirq_pkg::*;
#(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          nmi_req,
  input  logic          take_en,
  input  logic          psw_i,
  input  logic          req,
  input  logic [DW-1:0] pend,
  input  logic [DW-1:0] mask,
  output logic          take_ext,
  output logic          take_nmi
);
  logic       nmi_pend;
  take_kind_e kind;

  always_comb begin
    kind = TAKE_NONE;
    if (take_en) begin
      if (nmi_pend)                          kind = TAKE_NMI;
      else if (req && psw_i && |(pend & mask)) kind = TAKE_EXT;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend <= 1'b0;
      take_ext <= 1'b0;
      take_nmi <= 1'b0;
    end else begin
      nmi_pend <= nmi_req || (nmi_pend && (kind != TAKE_NMI));
      take_ext <= (kind == TAKE_EXT);
      take_nmi <= (kind == TAKE_NMI);
    end
  end
endmodule

// File: rtl/xirq_rd_port.sv
module xirq_rd_port #(
  parameter int DW      = 64,
  parameter int ACC_LEN = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [2:0]    rd_len,
  input  logic [DW-1:0] pend,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  logic rd_ok;

  assign rd_ok = rd_en && (rd_len == 3'(ACC_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_ok;
      if (rd_ok) rd_data <= pend;
    end
  end
endmodule

// File: rtl/xirq_ctrl.sv
module xirq_ctrl #(
  parameter int DW      = 64,
  parameter int NW      = 32,
  parameter int AW      = 32,
  parameter int ACC_LEN = 4,
  parameter bit WIDE_OK = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wide,
  input  logic          bus_wr_en,
  input  logic [2:0]    bus_wr_len,
  input  logic [AW-1:0] bus_wr_data,
  input  logic          bus_rd_en,
  input  logic [2:0]    bus_rd_len,
  output logic          bus_rd_valid,
  output logic [DW-1:0] bus_rd_data,
  input  logic          timer_alarm,
  input  logic          cpu_clr_en,
  input  logic [DW-1:0] cpu_clr_mask,
  input  logic          cpu_mask_we,
  input  logic [DW-1:0] cpu_mask_data,
  output logic [DW-1:0] cpu_pend,
  output logic [DW-1:0] cpu_mask,
  input  logic          psw_i,
  input  logic          nmi_req,
  input  logic          take_en,
  output logic          hard_req,
  output logic          take_ext,
  output logic          take_nmi
);
  logic [DW-1:0] set_vec;

  xirq_post_dec #(.DW(DW), .NW(NW), .AW(AW), .ACC_LEN(ACC_LEN), .WIDE_OK(WIDE_OK)) u_dec (
    .cfg_wide    (cfg_wide),
    .bus_wr_en   (bus_wr_en),
    .bus_wr_len  (bus_wr_len),
    .bus_wr_data (bus_wr_data),
    .timer_alarm (timer_alarm),
    .set_vec     (set_vec)
  );

  xirq_pend_reg #(.DW(DW)) u_pend (
    .clk       (clk),
    .rst       (rst),
    .set_vec   (set_vec),
    .clr_en    (cpu_clr_en),
    .clr_mask  (cpu_clr_mask),
    .mask_we   (cpu_mask_we),
    .mask_data (cpu_mask_data),
    .pend_q    (cpu_pend),
    .mask_q    (cpu_mask),
    .req_q     (hard_req)
  );

  xirq_take_arb #(.DW(DW)) u_arb (
    .clk      (clk),
    .rst      (rst),
    .nmi_req  (nmi_req),
    .take_en  (take_en),
    .psw_i    (psw_i),
    .req      (hard_req),
    .pend     (cpu_pend),
    .mask     (cpu_mask),
    .take_ext (take_ext),
    .take_nmi (take_nmi)
  );

  xirq_rd_port #(.DW(DW), .ACC_LEN(ACC_LEN)) u_rd (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (bus_rd_en),
    .rd_len   (bus_rd_len),
    .pend     (cpu_pend),
    .rd_valid (bus_rd_valid),
    .rd_data  (bus_rd_data)
  );
endmodule

// File: rtl/xirq_ctrl_chk.sv
module xirq_ctrl_chk #(
  parameter int DW      = 64,
  parameter int ACC_LEN = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr_en,
  input logic          bus_rd_en,
  input logic [2:0]    bus_rd_len,
  input logic          bus_rd_valid,
  input logic [DW-1:0] bus_rd_data,
  input logic          timer_alarm,
  input logic          cpu_clr_en,
  input logic [DW-1:0] cpu_clr_mask,
  input logic [DW-1:0] cpu_pend,
  input logic          psw_i,
  input logic          take_en,
  input logic          hard_req,
  input logic          take_ext,
  input logic          take_nmi
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (cpu_pend == '0) && !hard_req && !take_ext && !take_nmi && !bus_rd_valid);

  a_r9_req_tracks_pend: assert property (@(posedge clk) disable iff (rst)
    hard_req == (cpu_pend != '0));

  a_r5_clear_only: assert property (@(posedge clk) disable iff (rst)
    (cpu_clr_en && !bus_wr_en && !timer_alarm) |=> ((cpu_pend & $past(cpu_clr_mask)) == '0));

  a_r4_bad_read_len: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (bus_rd_len != 3'(ACC_LEN))) |=> !bus_rd_valid);

  a_r8_read_snapshot: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && (bus_rd_len == 3'(ACC_LEN))) |=> bus_rd_valid && (bus_rd_data == $past(cpu_pend)));

  a_r11_one_take: assert property (@(posedge clk) disable iff (rst)
    !(take_ext && take_nmi));

  a_r10_ext_gated: assert property (@(posedge clk) disable iff (rst)
    take_ext |-> ($past(take_en) && $past(psw_i) && $past(hard_req)));
endmodule

bind xirq_ctrl xirq_ctrl_chk #(.DW(DW), .ACC_LEN(ACC_LEN)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .bus_wr_en    (bus_wr_en),
  .bus_rd_en    (bus_rd_en),
  .bus_rd_len   (bus_rd_len),
  .bus_rd_valid (bus_rd_valid),
  .bus_rd_data  (bus_rd_data),
  .timer_alarm  (timer_alarm),
  .cpu_clr_en   (cpu_clr_en),
  .cpu_clr_mask (cpu_clr_mask),
  .cpu_pend     (cpu_pend),
  .psw_i        (psw_i),
  .take_en      (take_en),
  .hard_req     (hard_req),
  .take_ext     (take_ext),
  .take_nmi     (take_nmi)
);

// File: tb/xirq_ctrl_bench.sv
module xirq_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wide = 1'b0;
  logic        bus_wr_en = 1'b0;
  logic [2:0]  bus_wr_len = 3'd4;
  logic [31:0] bus_wr_data = '0;
  logic        bus_rd_en = 1'b0;
  logic [2:0]  bus_rd_len = 3'd4;
  logic        bus_rd_valid;
  logic [63:0] bus_rd_data;
  logic        timer_alarm = 1'b0;
  logic        cpu_clr_en = 1'b0;
  logic [63:0] cpu_clr_mask = '0;
  logic        cpu_mask_we = 1'b0;
  logic [63:0] cpu_mask_data = '0;
  logic [63:0] cpu_pend;
  logic [63:0] cpu_mask;
  logic        psw_i = 1'b0;
  logic        nmi_req = 1'b0;
  logic        take_en = 1'b0;
  logic        hard_req;
  logic        take_ext;
  logic        take_nmi;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  xirq_ctrl u_xirq_ctrl (.*);

  // behavioural reference model
  logic [63:0] m_pend, m_mask, m_rdd;
  logic        m_req, m_ext, m_nmi, m_nmi_p, m_rdv;

  always @(posedge clk) begin
    logic [63:0] n;
    int w, idx;
    if (rst) begin
      m_pend = '0; m_mask = '0; m_rdd = '0;
      m_req = 0; m_ext = 0; m_nmi = 0; m_nmi_p = 0; m_rdv = 0;
    end else begin
      w = cfg_wide ? 64 : 32;
      n = m_pend;
      if (cpu_clr_en) n = n & ~cpu_clr_mask;
      if (bus_wr_en && bus_wr_len == 3'd4) begin
        idx = int'(~bus_wr_data) % w;
        if (idx < 0) idx = idx + w;
        n[idx] = 1'b1;
      end
      if (timer_alarm) n[w-1] = 1'b1;
      m_rdv = bus_rd_en && bus_rd_len == 3'd4;
      if (m_rdv) m_rdd = m_pend;
      m_nmi = take_en && m_nmi_p;
      m_ext = take_en && !m_nmi_p && psw_i && ((m_pend & m_mask) != 0);
      m_nmi_p = nmi_req || (m_nmi_p && !take_en);
      if (cpu_mask_we) m_mask = cpu_mask_data;
      m_pend = n;
      m_req = (n != 0);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(cpu_pend == m_pend, "R2 pend", cpu_pend, m_pend);
      check(cpu_mask == m_mask, "R12 mask", cpu_mask, m_mask);
      check(hard_req == m_req, "R9 hard_req", 64'(hard_req), 64'(m_req));
      check(take_ext == m_ext, "R10 take_ext", 64'(take_ext), 64'(m_ext));
      check(take_nmi == m_nmi, "R11 take_nmi", 64'(take_nmi), 64'(m_nmi));
      check(bus_rd_valid == m_rdv, "R8 rd_valid", 64'(bus_rd_valid), 64'(m_rdv));
      if (m_rdv) check(bus_rd_data == m_rdd, "R8 rd_data", bus_rd_data, m_rdd);
    end
  end

  task automatic post(input logic [31:0] d, input logic [2:0] len);
    @(negedge clk); bus_wr_en = 1; bus_wr_data = d; bus_wr_len = len;
    @(negedge clk); bus_wr_en = 0; bus_wr_len = 3'd4;
  endtask

  task automatic clr(input logic [63:0] m);
    @(negedge clk); cpu_clr_en = 1; cpu_clr_mask = m;
    @(negedge clk); cpu_clr_en = 0;
  endtask

  task automatic take_cycle();
    @(negedge clk); take_en = 1;
    @(negedge clk); take_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(cpu_pend == 0 && cpu_mask == 0 && !hard_req && !take_ext && !take_nmi && !bus_rd_valid,
          "R1 reset", cpu_pend, 64'd0);

    post(32'd0, 3'd4);
    check(cpu_pend == 64'h8000_0000, "R2 d=0 narrow", cpu_pend, 64'h8000_0000);
    post(32'd33, 3'd4);
    post(32'd5, 3'd4);
    check(cpu_pend == 64'hC400_0000, "R2 d=33,5", cpu_pend, 64'hC400_0000);
    post(32'd1, 3'd2);
    check(cpu_pend == 64'hC400_0000, "R4 short write", cpu_pend, 64'hC400_0000);
    @(negedge clk); bus_rd_en = 1; bus_rd_len = 3'd1;
    @(negedge clk); bus_rd_en = 0; bus_rd_len = 3'd4;
    check(!bus_rd_valid, "R4 short read", 64'(bus_rd_valid), 64'd0);

    clr(64'h4000_0000);
    check(cpu_pend == 64'h8400_0000, "R5 clear", cpu_pend, 64'h8400_0000);

    @(negedge clk); cpu_clr_en = 1; cpu_clr_mask = '1; bus_wr_en = 1; bus_wr_data = 32'd3;
    @(negedge clk); cpu_clr_en = 0; bus_wr_en = 0;
    check(cpu_pend == 64'h1000_0000, "R6 clear+post", cpu_pend, 64'h1000_0000);

    @(negedge clk); timer_alarm = 1; bus_wr_en = 1; bus_wr_data = 32'd6;
    @(negedge clk); timer_alarm = 0; bus_wr_en = 0;
    check(cpu_pend == 64'h9200_0000, "R7 timer+post", cpu_pend, 64'h9200_0000);

    @(negedge clk); bus_rd_en = 1;
    @(negedge clk); bus_rd_en = 0;
    check(bus_rd_valid && bus_rd_data == 64'h9200_0000, "R8 read", bus_rd_data, 64'h9200_0000);

    clr('1);
    check(!hard_req, "R9 empty", 64'(hard_req), 64'd0);

    cfg_wide = 1;
    post(32'd0, 3'd4);
    post(32'd1, 3'd4);
    check(cpu_pend == 64'hC000_0000_0000_0000, "R3 wide", cpu_pend, 64'hC000_0000_0000_0000);
    clr('1);
    @(negedge clk); timer_alarm = 1;
    @(negedge clk); timer_alarm = 0;
    check(cpu_pend == 64'h8000_0000_0000_0000, "R7 timer wide", cpu_pend, 64'h8000_0000_0000_0000);
    cfg_wide = 0;
    clr('1);

    post(32'd31, 3'd4);
    psw_i = 1;
    take_cycle();
    check(!take_ext, "R10 mask empty", 64'(take_ext), 64'd0);
    @(negedge clk); cpu_mask_we = 1; cpu_mask_data = 64'h1;
    @(negedge clk); cpu_mask_we = 0;
    check(cpu_mask == 64'h1, "R12 mask load", cpu_mask, 64'h1);
    psw_i = 0;
    take_cycle();
    check(!take_ext, "R10 psw_i low", 64'(take_ext), 64'd0);
    psw_i = 1;
    take_cycle();
    check(take_ext, "R10 taken", 64'(take_ext), 64'd1);

    @(negedge clk); nmi_req = 1;
    @(negedge clk); nmi_req = 0;
    take_cycle();
    check(take_nmi && !take_ext, "R11 nmi wins", {62'd0, take_nmi, take_ext}, 64'd2);
    take_cycle();
    check(!take_nmi && take_ext, "R11 nmi dropped", {62'd0, take_nmi, take_ext}, 64'd1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule